// File: doc/BRIEF.md
# SPI Control Register Access Target

This block is the device-side end of the control channel on a serial peripheral link. It turns a stream of host bits into 32-bit words. It reads the first word of each chip-select frame as a control header, and then serves a read or a write burst against a small register bank. The host clocks one bit per `bit_strobe` pulse and receives one bit back on each pulse. Everything the device returns runs one word behind what the host sends. In the second word slot the device returns the header. In the slots after that it returns either the register contents (for a read) or the data the host just wrote (for a write). The host can therefore see which word of a write went wrong.

Header layout, MSB first:
- bit 31 is the data-word flag, and must be 0 for a control command.
- bit 29 is the write flag (1 = write, 0 = read).
- bits 27:24 select the register map.
- bits 23:8 hold the start address.
- bits 7:1 hold the word count minus one.
- bit 0 is set so that the 32 header bits have an odd number of ones.

A command of N words occupies N+2 word slots: the header, then N slots, then one trailing slot.

The controller has six named states:
- **HEADER**: waits for the first word. A valid read goes to **READ**, a valid write goes to **WRITE**, and a bad header goes to **ABORT**.
- **READ**: after N words, goes to **DONE**.
- **WRITE**: after N words, goes to **WTAIL**.
- **WTAIL**: after the trailing word, goes to **DONE**.
- **DONE** and **ABORT**: hold until chip select is released.

Releasing the frame returns the controller from any state to **HEADER**.

Top module: `spi_ctl_target`

## Requirements
- R1: After reset, `miso` is 0, word 0 of `reg_image` holds the `ID_VALUE` parameter, and words 1 to NUM_REGS-1 are zero.
- R2: During the header slot `miso` is all zeros. In the next slot the device returns the received header unchanged, for both reads and writes.
- R3: A read of N words returns register A in slot 2, A+1 in slot 3, and so on up to slot N+1. The address is post-incremented. Host words sent during a read change no register.
- R4: A read of an address outside the bank returns zero. Outside the bank means a map selector other than `SEL_VALUE`, or an address of NUM_REGS or more.
- R5: In a write of N words, the data word of slot k (1..N) is stored at address A+k-1. The same word is returned in slot k+1.
- R6: The word the host sends in slot N+1 of a write is ignored, so register A+N keeps its value.
- R7: Writes to address 0 (the read-only identification word) are dropped. So are writes to addresses outside the bank. Writes inside the same burst to implemented addresses still land.
- R8: A header whose 32 bits hold an even number of ones aborts the frame. `miso` stays 0 for the rest of the frame and no register changes.
- R9: A header with bit 31 set is not a control command. It gets the same treatment as R8.
- R10: After slot N+1, `miso` is 0 and further host words change no register until chip select is released.
- R11: Dropping `frame_active` in any state ends the command. Words already written stay written, and the next frame starts with a new header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_active | input | 1 | High while chip select is asserted |
| bit_strobe | input | 1 | One-cycle pulse per serial bit; samples `mosi` and advances `miso` |
| mosi | input | 1 | Host-to-device serial bit, MSB first |
| miso | output | 1 | Device-to-host serial bit, MSB first |
| reg_image | output | NUM_REGS*32 | Current contents of the register bank, word i at bits 32*i+31:32*i |

## Verification
The checker assumes that `bit_strobe` arrives only while `frame_active` is high. It also assumes that chip select is released only at a word boundary or when a command is deliberately cut short. The properties on stored words and on stable registers hold only if the serial stream keeps this framing.

The bench drives every bit through one task that raises the strobe for exactly one cycle after setting `mosi`. It builds each frame as a whole number of 32-bit words. When it cuts a frame short, it does so only between words.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 16;
    localparam int SEL_W  = 4;
    localparam int LEN_W  = 7;
    localparam int CNT_W  = LEN_W + 1;

    typedef enum logic [2:0] {
        ST_HEADER,
        ST_READ,
        ST_WRITE,
        ST_WTAIL,
        ST_DONE,
        ST_ABORT
    } ctl_state_t;

    typedef struct packed {
        logic              is_data;
        logic              is_write;
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  count;
        logic              parity_ok;
    } ctl_hdr_t;

endpackage

// File: rtl/ctl_word_shifter.sv
module ctl_word_shifter
    import spi_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_active,
    input  logic              bit_strobe,
    input  logic              mosi,
    input  logic [WORD_W-1:0] load_word,
    output logic              word_done,
    output logic [WORD_W-1:0] rx_word,
    output logic              miso
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    logic [BIT_W-1:0]  bit_cnt_q;
    logic [WORD_W-2:0] rx_sh_q;
    logic [WORD_W-1:0] tx_sh_q;

    // the strobe that completes a word also hands out the next transmit word
    assign word_done = frame_active && bit_strobe && (bit_cnt_q == LAST_BIT);
    assign rx_word   = {rx_sh_q, mosi};
    assign miso      = frame_active && tx_sh_q[WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            tx_sh_q   <= '0;
        end else if (!frame_active) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            tx_sh_q   <= '0;
        end else if (bit_strobe) begin
            rx_sh_q <= {rx_sh_q[WORD_W-3:0], mosi};
            if (bit_cnt_q == LAST_BIT) begin
                bit_cnt_q <= '0;
                tx_sh_q   <= load_word;
            end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                tx_sh_q   <= {tx_sh_q[WORD_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/ctl_hdr_decode.sv
module ctl_hdr_decode
    import spi_ctl_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output ctl_hdr_t          hdr,
    output logic              accept
);

    always_comb begin
        hdr.is_data   = word[31];
        hdr.is_write  = word[29];
        hdr.sel       = word[27:24];
        hdr.addr      = word[23:8];
        hdr.count     = {1'b0, word[7:1]} + CNT_W'(1);
        // odd parity over the whole header, reserved bits included
        hdr.parity_ok = ^word;
    end

    assign accept = !hdr.is_data && hdr.parity_ok;

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
    import spi_ctl_pkg::*;
#(
    parameter int               NUM_REGS  = 8,
    parameter logic [SEL_W-1:0] SEL_VALUE = '0,
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h1C0A_0001
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_req,
    input  logic [SEL_W-1:0]           acc_sel,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic [WORD_W-1:0]          wr_data,
    output logic [WORD_W-1:0]          rd_data,
    output logic [NUM_REGS*WORD_W-1:0] image
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic             in_range;
    logic [IDX_W-1:0] idx;

    assign in_range = (acc_sel == SEL_VALUE) && (acc_addr < ADDR_W'(NUM_REGS));
    assign idx      = acc_addr[IDX_W-1:0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        if (g == 0) begin : g_id
            // identification word: fixed, writes have no path here
            assign image[WORD_W-1:0] = ID_VALUE;
        end else begin : g_rw
            logic [WORD_W-1:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (wr_req && in_range && (idx == IDX_W'(g))) begin
                    val_q <= wr_data;
                end
            end
            assign image[g*WORD_W +: WORD_W] = val_q;
        end
    end

    always_comb begin
        rd_data = '0;
        if (in_range) begin
            rd_data = image[int'(idx)*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/spi_ctl_target.sv
module spi_ctl_target
    import spi_ctl_pkg::*;
#(
    parameter int               NUM_REGS  = 8,
    parameter logic [SEL_W-1:0] SEL_VALUE = '0,
    parameter logic [WORD_W-1:0] ID_VALUE = 32'h1C0A_0001
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_active,
    input  logic                       bit_strobe,
    input  logic                       mosi,
    output logic                       miso,
    output logic [NUM_REGS*WORD_W-1:0] reg_image
);

    ctl_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [SEL_W-1:0]  sel_q, sel_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    logic              word_done;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] load_word;
    logic [WORD_W-1:0] rd_data;
    logic              wr_req;
    ctl_hdr_t          hdr;
    logic              hdr_accept;

    ctl_word_shifter u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_active (frame_active),
        .bit_strobe   (bit_strobe),
        .mosi         (mosi),
        .load_word    (load_word),
        .word_done    (word_done),
        .rx_word      (rx_word),
        .miso         (miso)
    );

    ctl_hdr_decode u_hdr (
        .word   (rx_word),
        .hdr    (hdr),
        .accept (hdr_accept)
    );

    ctl_reg_bank #(
        .NUM_REGS  (NUM_REGS),
        .SEL_VALUE (SEL_VALUE),
        .ID_VALUE  (ID_VALUE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .acc_sel  (sel_q),
        .acc_addr (addr_q),
        .wr_data  (rx_word),
        .rd_data  (rd_data),
        .image    (reg_image)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HEADER;
            addr_q  <= '0;
            sel_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            sel_q   <= sel_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs; load_word is what the host sees in the next slot
    always_comb begin
        state_d   = state_q;
        addr_d    = addr_q;
        sel_d     = sel_q;
        cnt_d     = cnt_q;
        load_word = '0;
        wr_req    = 1'b0;

        unique case (state_q)
            ST_HEADER: begin
                if (word_done) begin
                    if (hdr_accept) begin
                        load_word = rx_word;
                        addr_d    = hdr.addr;
                        sel_d     = hdr.sel;
                        cnt_d     = hdr.count;
                        state_d   = hdr.is_write ? ST_WRITE : ST_READ;
                    end else begin
                        state_d = ST_ABORT;
                    end
                end
            end
            ST_READ: begin
                if (word_done) begin
                    load_word = rd_data;
                    addr_d    = addr_q + 1'b1;
                    cnt_d     = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_WRITE: begin
                if (word_done) begin
                    wr_req    = 1'b1;
                    load_word = rx_word;
                    addr_d    = addr_q + 1'b1;
                    cnt_d     = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        state_d = ST_WTAIL;
                    end
                end
            end
            ST_WTAIL: begin
                if (word_done) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            ST_ABORT: begin
                state_d = ST_ABORT;
            end
        endcase

        if (!frame_active) begin
            state_d = ST_HEADER;
        end
    end

endmodule

// File: rtl/spi_ctl_target_chk.sv
module spi_ctl_target_chk
    import spi_ctl_pkg::*;
#(
    parameter int               NUM_REGS  = 8,
    parameter logic [SEL_W-1:0] SEL_VALUE = '0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       frame_active,
    input logic                       miso,
    input ctl_state_t                 state,
    input logic                       wr_req,
    input logic [SEL_W-1:0]           acc_sel,
    input logic [ADDR_W-1:0]          acc_addr,
    input logic [WORD_W-1:0]          wr_data,
    input logic [NUM_REGS*WORD_W-1:0] reg_image
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              hit;
    logic [IDX_W-1:0]  prev_idx;
    logic [WORD_W-1:0] prev_data;
    logic [WORD_W-1:0] landed_word;

    assign hit = (acc_sel == SEL_VALUE) && (acc_addr != '0) &&
                 (acc_addr < ADDR_W'(NUM_REGS));

    always_ff @(posedge clk) begin
        prev_idx  <= acc_addr[IDX_W-1:0];
        prev_data <= wr_data;
    end

    assign landed_word = reg_image[int'(prev_idx)*WORD_W +: WORD_W];

    a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ABORT |-> !miso);

    a_r8_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ABORT |-> !wr_req);

    a_r3_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_READ |-> !wr_req);

    a_r6_tail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WTAIL |-> !wr_req);

    a_r10_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DONE |-> !wr_req);

    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && hit |=> landed_word == prev_data);

    a_r7_drop_stable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !hit |=> $stable(reg_image));

    a_r11_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |=> state == ST_HEADER);

endmodule

bind spi_ctl_target spi_ctl_target_chk #(
    .NUM_REGS  (NUM_REGS),
    .SEL_VALUE (SEL_VALUE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_active (frame_active),
    .miso         (miso),
    .state        (state_q),
    .wr_req       (wr_req),
    .acc_sel      (sel_q),
    .acc_addr     (addr_q),
    .wr_data      (rx_word),
    .reg_image    (reg_image)
);

// File: tb/test_spi_ctl_target.sv
module test_spi_ctl_target;

    localparam int          NREG = 8;
    localparam logic [31:0] ID   = 32'h1C0A_0001;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_active = 1'b0;
    logic              bit_strobe = 1'b0;
    logic              mosi = 1'b0;
    logic              miso;
    logic [NREG*32-1:0] reg_image;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] tx_q [16];
    logic [31:0] rx_q [16];
    logic [31:0] exp_reg [NREG];

    always #10 clk = ~clk;

    spi_ctl_target #(.NUM_REGS(NREG), .SEL_VALUE(4'd0), .ID_VALUE(ID)) i_spi_ctl_target (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_active (frame_active),
        .bit_strobe   (bit_strobe),
        .mosi         (mosi),
        .miso         (miso),
        .reg_image    (reg_image)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_hdr(input bit dnc, input bit wr,
                                           input logic [3:0] sel,
                                           input logic [15:0] addr, input int n);
        logic [31:0] h;
        h        = '0;
        h[31]    = dnc;
        h[29]    = wr;
        h[27:24] = sel;
        h[23:8]  = addr;
        h[7:1]   = 7'(n - 1);
        h[0]     = ~(^h[31:1]);
        return h;
    endfunction

    task automatic check_image(input string tag);
        for (int i = 0; i < NREG; i++) begin
            chk(tag, reg_image[i*32 +: 32], exp_reg[i]);
        end
    endtask

    task automatic spi_word(input logic [31:0] w, output logic [31:0] r);
        for (int b = 31; b >= 0; b--) begin
            @(negedge clk);
            r[b]       = miso;
            mosi       = w[b];
            bit_strobe = 1'b1;
            @(negedge clk);
            bit_strobe = 1'b0;
        end
    endtask

    task automatic run_frame(input int n);
        @(negedge clk);
        frame_active = 1'b1;
        for (int i = 0; i < n; i++) begin
            spi_word(tx_q[i], rx_q[i]);
        end
        @(negedge clk);
        frame_active = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 miso", {31'b0, miso}, 32'h0);
        check_image("R1 image");
    endtask

    task automatic t_read_id();
        tx_q[0] = mk_hdr(0, 0, 4'd0, 16'd0, 1);
        tx_q[1] = 32'hFFFF_FFFF;
        tx_q[2] = 32'hA5A5_A5A5;
        run_frame(3);
        chk("R2 header slot", rx_q[0], 32'h0);
        chk("R2 header echo", rx_q[1], tx_q[0]);
        chk("R3 id word", rx_q[2], ID);
    endtask

    task automatic t_write_burst();
        tx_q[0] = mk_hdr(0, 1, 4'd0, 16'd2, 3);
        tx_q[1] = 32'h1111_1111;
        tx_q[2] = 32'h2222_2222;
        tx_q[3] = 32'h3333_3333;
        tx_q[4] = 32'h4444_4444;
        run_frame(5);
        chk("R2 write header slot", rx_q[0], 32'h0);
        chk("R2 write echo", rx_q[1], tx_q[0]);
        for (int i = 0; i < 3; i++) begin
            chk("R5 data echo", rx_q[2+i], tx_q[1+i]);
            exp_reg[2+i] = tx_q[1+i];
        end
        check_image("R5 burst stored");
        chk("R6 final word ignored", reg_image[5*32 +: 32], 32'h0);
    endtask

    task automatic t_read_burst();
        tx_q[0] = mk_hdr(0, 0, 4'd0, 16'd1, 5);
        for (int i = 1; i < 7; i++) tx_q[i] = 32'hFFFF_FFFF;
        run_frame(7);
        chk("R2 read echo", rx_q[1], tx_q[0]);
        for (int i = 0; i < 5; i++) begin
            chk("R3 burst data", rx_q[2+i], exp_reg[1+i]);
        end
        check_image("R3 host data ignored");
    endtask

    task automatic t_unimpl_write();
        tx_q[0] = mk_hdr(0, 1, 4'd0, 16'd6, 4);
        tx_q[1] = 32'h6666_6666;
        tx_q[2] = 32'h7777_7777;
        tx_q[3] = 32'h8888_8888;
        tx_q[4] = 32'h9999_9999;
        tx_q[5] = 32'h0;
        run_frame(6);
        exp_reg[6] = tx_q[1];
        exp_reg[7] = tx_q[2];
        chk("R7 echo past end", rx_q[5], tx_q[4]);
        check_image("R7 partial burst");
        tx_q[0] = mk_hdr(0, 1, 4'd0, 16'd0, 1);
        tx_q[1] = 32'hDEAD_BEEF;
        tx_q[2] = 32'h0;
        run_frame(3);
        check_image("R7 id read-only");
        tx_q[0] = mk_hdr(0, 1, 4'd5, 16'd3, 1);
        tx_q[1] = 32'hFACE_FACE;
        tx_q[2] = 32'h0;
        run_frame(3);
        check_image("R7 other map");
    endtask

    task automatic t_unimpl_read();
        tx_q[0] = mk_hdr(0, 0, 4'd0, 16'd6, 4);
        for (int i = 1; i < 6; i++) tx_q[i] = 32'h0;
        run_frame(6);
        chk("R4 reg6", rx_q[2], exp_reg[6]);
        chk("R4 reg7", rx_q[3], exp_reg[7]);
        chk("R4 addr8 zero", rx_q[4], 32'h0);
        chk("R4 addr9 zero", rx_q[5], 32'h0);
        tx_q[0] = mk_hdr(0, 0, 4'd2, 16'd2, 1);
        run_frame(3);
        chk("R4 other map zero", rx_q[2], 32'h0);
    endtask

    task automatic t_bad_header(input bit data_flag);
        if (data_flag) tx_q[0] = mk_hdr(1, 1, 4'd0, 16'd1, 1);
        else           tx_q[0] = mk_hdr(0, 1, 4'd0, 16'd1, 1) ^ 32'h1;
        tx_q[1] = 32'hCAFE_0001;
        tx_q[2] = 32'hCAFE_0002;
        tx_q[3] = 32'hCAFE_0003;
        run_frame(4);
        for (int i = 0; i < 4; i++) begin
            if (data_flag) chk("R9 silent", rx_q[i], 32'h0);
            else           chk("R8 silent", rx_q[i], 32'h0);
        end
        if (data_flag) check_image("R9 no write");
        else           check_image("R8 no write");
    endtask

    task automatic t_after_done();
        tx_q[0] = mk_hdr(0, 1, 4'd0, 16'd1, 1);
        tx_q[1] = 32'h0BAD_F00D;
        tx_q[2] = 32'h0000_0001;
        tx_q[3] = 32'h1234_5678;
        tx_q[4] = 32'h9ABC_DEF0;
        run_frame(5);
        exp_reg[1] = tx_q[1];
        chk("R10 echo", rx_q[2], tx_q[1]);
        chk("R10 quiet slot3", rx_q[3], 32'h0);
        chk("R10 quiet slot4", rx_q[4], 32'h0);
        check_image("R10 extra words ignored");
    endtask

    task automatic t_frame_drop();
        tx_q[0] = mk_hdr(0, 1, 4'd0, 16'd3, 4);
        tx_q[1] = 32'h3030_3030;
        tx_q[2] = 32'h4040_4040;
        run_frame(3);
        exp_reg[3] = tx_q[1];
        exp_reg[4] = tx_q[2];
        check_image("R11 partial write kept");
        tx_q[0] = mk_hdr(0, 0, 4'd0, 16'd3, 3);
        for (int i = 1; i < 5; i++) tx_q[i] = 32'h0;
        run_frame(5);
        chk("R11 new header echo", rx_q[1], tx_q[0]);
        for (int i = 0; i < 3; i++) begin
            chk("R11 read after drop", rx_q[2+i], exp_reg[3+i]);
        end
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) exp_reg[i] = 32'h0;
        exp_reg[0] = ID;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_id();
        t_write_burst();
        t_read_burst();
        t_unimpl_write();
        t_unimpl_read();
        t_bad_header(1'b0);
        t_bad_header(1'b1);
        t_after_done();
        t_frame_drop();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule